// File: doc/BRIEF.md
# Interrupt-Capable GPIO Port

This block is a 32-pin general-purpose I/O port that a processor controls through a small synchronous register bus. Each pin has an output value and an output-enable bit. The block resynchronises the pad inputs and lets software read their levels. Each pin can raise a per-pin event flag when its input is low, is high, rises or falls. A separate per-pin bit makes the pin respond to both edges and overrides its 2-bit code.

The event flags are sticky, and writing 1 to a flag bit clears it. The flags are ANDed with an enable mask and ORed into one registered interrupt line. Software sets up a pin with a few register writes. It then services the line by reading the flag register and writing back the bits it has handled.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, every register reads 0, `pad_oe` is 0 and `irq` is 0. Register offsets: 0x00 output value, 0x04 output enable, 0x08 pad levels, 0x0C trigger codes for pins 0..15, 0x10 trigger codes for pins 16..31, 0x14 interrupt enable mask, 0x18 event flags, 0x1C any-edge select. Bits 4:2 of `bus_addr` choose the register.
- R2: The output-value, output-enable, both trigger-code, mask and any-edge registers keep the value last written and return it on a read. Read data appears on `bus_rdata` one cycle after `bus_rd` and then holds.
- R3: `pad_out` carries the output-value register and `pad_oe` carries the output-enable register, where 1 means the pin drives. Both follow a write on the next cycle.
- R4: A read at offset 0x08 returns `pad_in` delayed by a two-flop synchroniser. A write to 0x08 has no effect.
- R5: Pin n takes its code from bits [2n+1:2n] of register 0x0C when n < 16, and from bits [2(n-16)+1:2(n-16)] of register 0x10 otherwise. The codes are 0 = input low, 1 = input high, 2 = rising edge, 3 = falling edge. An edge code ignores the opposite edge.
- R6: In a level mode, a flag that is cleared while the level is still present reads 1 again. When a set and a clear fall in the same cycle, the set wins.
- R7: When a pin's any-edge bit is 1, both edges set its flag and its 2-bit code has no effect.
- R8: Writing 1 to a bit of the flag register clears that flag. Writing 0 leaves it unchanged. No flag falls at any other time.
- R9: A flag is set by its trigger whatever the mask holds.
- R10: `irq` is 1 exactly one cycle after some bit of (flags AND mask) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Pad input levels |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |
| irq | output | 1 | Interrupt request |

## Verification
If the flag register holds a wrong value, the fault shows on the first read of offset 0x18. Once that bit is enabled in the mask, it also shows on `irq` one cycle later. A bit that is wrongly lost cannot be restored by an edge trigger, so the bench reads the flags after every pad change. A slip in the synchroniser or the edge compare shows up as flags that fire on the wrong edge, or on both edges, two cycles after the pad moves. A pin that is mapped to the wrong code field sets a different pin's flag. The bench therefore uses pins in both halves of the port.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  // word index of each register: bus_addr[4:2]
  typedef enum logic [2:0] {
    REG_OUTVAL  = 3'd0,
    REG_OUTEN   = 3'd1,
    REG_PADS    = 3'd2,
    REG_TRIG_LO = 3'd3,
    REG_TRIG_HI = 3'd4,
    REG_MASK    = 3'd5,
    REG_FLAG    = 3'd6,
    REG_ANYEDGE = 3'd7
  } reg_sel_e;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_HIGH = 2'd1,
    TRIG_RISE = 2'd2,
    TRIG_FALL = 2'd3
  } trig_e;
endpackage

// File: rtl/gpio_reset_sync.sv
module gpio_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] cur,
  output logic [NPINS-1:0] prev
);
  logic [NPINS-1:0] meta_q, cur_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pad_in;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  assign cur  = cur_q;
  assign prev = prev_q;
endmodule

// File: rtl/gpio_trigger.sv
module gpio_trigger
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic [NPINS-1:0] cur,
  input  logic [NPINS-1:0] prev,
  input  logic [NPINS-1:0] trig_lo,
  input  logic [NPINS-1:0] trig_hi,
  input  logic [NPINS-1:0] anyedge,
  output logic [NPINS-1:0] hit
);
  localparam int unsigned HALF = NPINS / 2;

  logic [NPINS-1:0] rise, fall;
  assign rise = cur & ~prev;
  assign fall = ~cur & prev;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic [1:0] code;
    if (p < HALF) begin : g_lo
      assign code = trig_lo[2*p +: 2];
    end else begin : g_hi
      assign code = trig_hi[2*(p-HALF) +: 2];
    end

    always_comb begin
      if (anyedge[p]) begin
        hit[p] = rise[p] | fall[p];
      end else begin
        case (trig_e'(code))
          TRIG_LOW:  hit[p] = ~cur[p];
          TRIG_HIGH: hit[p] = cur[p];
          TRIG_RISE: hit[p] = rise[p];
          default:   hit[p] = fall[p];
        endcase
      end
    end
  end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [NPINS-1:0]  bus_wdata,
  input  logic [NPINS-1:0]  pad_cur,
  input  logic [NPINS-1:0]  hit,
  output logic [NPINS-1:0]  outval_q,
  output logic [NPINS-1:0]  outen_q,
  output logic [NPINS-1:0]  trig_lo_q,
  output logic [NPINS-1:0]  trig_hi_q,
  output logic [NPINS-1:0]  mask_q,
  output logic [NPINS-1:0]  flag_q,
  output logic [NPINS-1:0]  anyedge_q,
  output logic              irq_q,
  output logic [NPINS-1:0]  rdata_q
);
  localparam int unsigned SEL_LSB = 2;
  localparam int unsigned SEL_W   = 3;

  reg_sel_e         sel;
  logic [NPINS-1:0] outval_d, outen_d, trig_lo_d, trig_hi_d;
  logic [NPINS-1:0] mask_d, flag_d, anyedge_d, rdata_d, clr;
  logic             irq_d;

  assign sel = reg_sel_e'(bus_addr[SEL_LSB +: SEL_W]);

  always_comb begin
    outval_d  = outval_q;
    outen_d   = outen_q;
    trig_lo_d = trig_lo_q;
    trig_hi_d = trig_hi_q;
    mask_d    = mask_q;
    anyedge_d = anyedge_q;
    clr       = '0;
    if (bus_wr) begin
      case (sel)
        REG_OUTVAL:  outval_d  = bus_wdata;
        REG_OUTEN:   outen_d   = bus_wdata;
        REG_TRIG_LO: trig_lo_d = bus_wdata;
        REG_TRIG_HI: trig_hi_d = bus_wdata;
        REG_MASK:    mask_d    = bus_wdata;
        REG_FLAG:    clr       = bus_wdata;
        REG_ANYEDGE: anyedge_d = bus_wdata;
        default:     ;
      endcase
    end
    flag_d = (flag_q & ~clr) | hit;
    irq_d  = |(flag_q & mask_q);
  end

  always_comb begin
    rdata_d = rdata_q;
    if (bus_rd) begin
      case (sel)
        REG_OUTVAL:  rdata_d = outval_q;
        REG_OUTEN:   rdata_d = outen_q;
        REG_PADS:    rdata_d = pad_cur;
        REG_TRIG_LO: rdata_d = trig_lo_q;
        REG_TRIG_HI: rdata_d = trig_hi_q;
        REG_MASK:    rdata_d = mask_q;
        REG_FLAG:    rdata_d = flag_q;
        default:     rdata_d = anyedge_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outval_q  <= '0;
      outen_q   <= '0;
      trig_lo_q <= '0;
      trig_hi_q <= '0;
      mask_q    <= '0;
      flag_q    <= '0;
      anyedge_q <= '0;
      irq_q     <= 1'b0;
      rdata_q   <= '0;
    end else begin
      outval_q  <= outval_d;
      outen_q   <= outen_d;
      trig_lo_q <= trig_lo_d;
      trig_hi_q <= trig_hi_d;
      mask_q    <= mask_d;
      flag_q    <= flag_d;
      anyedge_q <= anyedge_d;
      irq_q     <= irq_d;
      if (bus_rd) rdata_q <= rdata_d;
    end
  end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic              irq
);
  logic             rst_n_sync;
  logic [NPINS-1:0] pad_cur, pad_prev, hit;
  logic [NPINS-1:0] trig_lo, trig_hi, mask_q, flag_q, anyedge;

  gpio_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  gpio_pad_sync #(.NPINS(NPINS)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .pad_in (pad_in),
    .cur    (pad_cur),
    .prev   (pad_prev)
  );

  gpio_trigger #(.NPINS(NPINS)) u_trig (
    .cur     (pad_cur),
    .prev    (pad_prev),
    .trig_lo (trig_lo),
    .trig_hi (trig_hi),
    .anyedge (anyedge),
    .hit     (hit)
  );

  gpio_regfile #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .pad_cur   (pad_cur),
    .hit       (hit),
    .outval_q  (pad_out),
    .outen_q   (pad_oe),
    .trig_lo_q (trig_lo),
    .trig_hi_q (trig_hi),
    .mask_q    (mask_q),
    .flag_q    (flag_q),
    .anyedge_q (anyedge),
    .irq_q     (irq),
    .rdata_q   (bus_rdata)
  );
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n_sync,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [NPINS-1:0]  bus_wdata,
  input logic [NPINS-1:0]  pad_in,
  input logic [NPINS-1:0]  pad_cur,
  input logic [NPINS-1:0]  pad_oe,
  input logic [NPINS-1:0]  flag_q,
  input logic [NPINS-1:0]  mask_q,
  input logic              irq
);
  logic [1:0] age_q;

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync)        age_q <= 2'd0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R3
  outen_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (bus_wr && bus_addr[4:2] == 3'd1) |=> (pad_oe == $past(bus_wdata)));

  // R4
  pad_sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (age_q == 2'd3) |-> (pad_cur == $past(pad_in, 2)));

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !(bus_wr && bus_addr[4:2] == 3'd6) |=> (($past(flag_q) & ~flag_q) == '0));

  // R10
  irq_registered_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (age_q != 2'd0) |-> (irq == $past(|(flag_q & mask_q))));
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) chk_i (
  .clk        (clk),
  .rst_n_sync (rst_n_sync),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .bus_wdata  (bus_wdata),
  .pad_in     (pad_in),
  .pad_cur    (pad_cur),
  .pad_oe     (pad_oe),
  .flag_q     (flag_q),
  .mask_q     (mask_q),
  .irq        (irq)
);

// File: tb/gpio_irq_port_tb_top.sv
module gpio_irq_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [31:0] bus_wdata, bus_rdata, pad_in, pad_out, pad_oe;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  logic        rd_seen = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  gpio_irq_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // driver: pushes the expected read value
  task automatic bus_read(input logic [4:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  always @(posedge clk) rd_seen <= bus_rd;

  // monitor: read data is valid at the negedge after the read edge
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL scoreboard: unexpected read data %h expected none", bus_rdata);
      end else begin
        chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    #1_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_addr = '0; bus_wdata = '0; pad_in = '0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(4);

    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 pad_oe", pad_oe, 32'd0);
    bus_read(5'h00, 32'd0, "R1 outval");
    bus_read(5'h04, 32'd0, "R1 outen");
    bus_read(5'h0C, 32'd0, "R1 trig_lo");
    bus_read(5'h10, 32'd0, "R1 trig_hi");
    bus_read(5'h14, 32'd0, "R1 mask");
    bus_read(5'h1C, 32'd0, "R1 anyedge");

    // R2 / R3 register storage and pad drive
    bus_write(5'h00, 32'hA5A5_5A5A);
    bus_write(5'h04, 32'hFFFF_0000);
    chk("R3 pad_out", pad_out, 32'hA5A5_5A5A);
    chk("R3 pad_oe", pad_oe, 32'hFFFF_0000);
    bus_write(5'h0C, 32'h1234_5678);
    bus_write(5'h10, 32'h9ABC_DEF0);
    bus_write(5'h14, 32'h0F0F_0000);
    bus_write(5'h1C, 32'h8000_0001);
    bus_read(5'h00, 32'hA5A5_5A5A, "R2 outval");
    bus_read(5'h04, 32'hFFFF_0000, "R2 outen");
    bus_read(5'h0C, 32'h1234_5678, "R2 trig_lo");
    bus_read(5'h10, 32'h9ABC_DEF0, "R2 trig_hi");
    bus_read(5'h14, 32'h0F0F_0000, "R2 mask");
    bus_read(5'h1C, 32'h8000_0001, "R2 anyedge");
    bus_write(5'h14, 32'd0);
    bus_write(5'h1C, 32'd0);

    // R4 pad levels, write ignored
    pad_in = 32'h0F0F_1234;
    wait_cyc(4);
    bus_read(5'h08, 32'h0F0F_1234, "R4 pads");
    bus_write(5'h08, 32'hFFFF_FFFF);
    bus_read(5'h08, 32'h0F0F_1234, "R4 pads after write");
    pad_in = 32'd0;

    // all high level, pin 3 rising, pin 20 falling
    bus_write(5'h0C, 32'h5555_5595);
    bus_write(5'h10, 32'h5555_5755);
    wait_cyc(4);
    bus_write(5'h18, 32'hFFFF_FFFF);
    bus_read(5'h18, 32'd0, "R8 clear all");

    // R5 trigger codes and field positions
    pad_in = 32'h0010_0000;
    wait_cyc(4);
    bus_read(5'h18, 32'd0, "R5 rise on falling pin ignored");
    pad_in = 32'h0010_0008;
    wait_cyc(4);
    bus_read(5'h18, 32'h0000_0008, "R5 rising pin 3");
    pad_in = 32'h0000_0008;
    wait_cyc(4);
    bus_read(5'h18, 32'h0010_0008, "R5 falling pin 20");

    // R8 partial write-1-to-clear
    bus_write(5'h18, 32'h0000_0008);
    bus_read(5'h18, 32'h0010_0000, "R8 clear pin 3 only");
    bus_write(5'h18, 32'd0);
    bus_read(5'h18, 32'h0010_0000, "R8 write zero no effect");
    pad_in = 32'd0;
    wait_cyc(4);
    bus_read(5'h18, 32'h0010_0000, "R5 fall on rising pin ignored");
    bus_write(5'h18, 32'hFFFF_FFFF);
    bus_read(5'h18, 32'd0, "R8 clear all again");

    // R6 / R9 level mode re-set, mask zero
    pad_in = 32'h0000_0020;
    wait_cyc(4);
    bus_read(5'h18, 32'h0000_0020, "R9 set with mask zero");
    bus_write(5'h18, 32'h0000_0020);
    bus_read(5'h18, 32'h0000_0020, "R6 level re-sets after clear");
    chk("R9 irq stays low", {31'd0, irq}, 32'd0);
    pad_in = 32'd0;
    wait_cyc(4);
    bus_write(5'h18, 32'hFFFF_FFFF);
    bus_read(5'h18, 32'd0, "R6 cleared once level gone");

    // R7 any-edge overrides code
    bus_write(5'h1C, 32'h0000_0100);
    pad_in = 32'h0000_0100;
    wait_cyc(4);
    bus_read(5'h18, 32'h0000_0100, "R7 rising");
    bus_write(5'h18, 32'h0000_0100);
    wait_cyc(4);
    bus_read(5'h18, 32'd0, "R7 level code ignored");
    pad_in = 32'd0;
    wait_cyc(4);
    bus_read(5'h18, 32'h0000_0100, "R7 falling");

    // R10 masked interrupt output
    bus_write(5'h14, 32'h0000_0100);
    wait_cyc(3);
    chk("R10 irq on", {31'd0, irq}, 32'd1);
    bus_write(5'h14, 32'h0000_0200);
    wait_cyc(3);
    chk("R10 irq masked", {31'd0, irq}, 32'd0);
    bus_write(5'h14, 32'h0000_0100);
    wait_cyc(3);
    chk("R10 irq on again", {31'd0, irq}, 32'd1);
    bus_write(5'h18, 32'h0000_0100);
    wait_cyc(3);
    chk("R10 irq off after clear", {31'd0, irq}, 32'd0);

    // R5 low level code on pin 0
    bus_write(5'h0C, 32'h5555_5594);
    wait_cyc(4);
    bus_read(5'h18, 32'h0000_0001, "R5 low level pin 0");

    wait_cyc(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule